// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer in front of an analog-to-digital converter core. Software programs one 8-bit control register through a simple write/read port. The register picks a channel code, whether conversions walk through consecutive channels, whether the channel code addresses internal special channels, and whether sequences repeat. Each conversion starts with a sampling phase whose length comes from a 3-bit sample-time select input. The block then hands the conversion to the core and waits for the core's done handshake.

A sequence is a fixed number of conversions, set by a parameter (four by default). With the external trigger disabled, every write to the control register aborts whatever is running and starts a new sequence at once. With the trigger enabled, a write only arms the block. After that, each trigger edge that arrives while the block is idle runs exactly one sequence, whatever the continuous bit says. A sticky completion flag marks the end of the last conversion of a sequence, and the next register write clears it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00 and `sample_start`, `conv_start` and `seq_done` are all low.
- R2: At address `CTRL_ADDR` (default 5), bits 6..0 read back as written and bit 7 always reads 0. Reads at any other address return 0, and writes to any other address leave the register unchanged and start nothing.
- R3: A control write with `trig_en` low makes `sample_start` high in the cycle after the write. This holds even when a sequence is already running: that sequence is aborted and a new one starts from its first conversion, using the newly written channel code.
- R4: `conv_start` is a one-cycle pulse that comes exactly N cycles after the `sample_start` of the same conversion. N is 4, 6, 8, 10, 12, 16, 20 or 24 for `smp_sel` codes 000 through 111, and the code is taken at each `sample_start`.
- R5: `chan_num` changes only together with `sample_start`. The first conversion uses channel code bits 3..0. When multi-channel bit 4 is set, each later conversion uses the previous channel plus one, wrapping from 15 to 0; when bit 4 is clear, every conversion uses the programmed code. `chan_special` carries special-channel bit 6 from the start of the sequence.
- R6: After SEQ_LEN accepted `conv_done` pulses, `seq_done` goes high in the cycle after the last one and stays high until the next control write, which clears it. In single mode (bit 5 clear) no further `sample_start` follows.
- R7: With continuous bit 5 set and `trig_en` low, a new sequence restarts on the first programmed channel: `sample_start` is high in the cycle after the final `conv_done` of the previous sequence.
- R8: A control write with `trig_en` high starts nothing and arms the block. Each later rising edge of `ext_trig` seen while idle gives `sample_start` in the following cycle and runs exactly one sequence, even when bit 5 is set.
- R9: A trigger edge has no effect when the block is not armed: either no control write has been made since `trig_en` was last low, or a sequence is still running.
- R10: A `conv_done` pulse outside the converting phase is ignored. It neither shortens the sampling phase nor counts as a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| ext_trig | input | 1 | External trigger level (rising edge acts by default) |
| trig_en | input | 1 | Trigger mode enable |
| smp_sel | input | 3 | Sample-time select code |
| conv_done | input | 1 | Converter core finished the current conversion |
| sample_start | output | 1 | One-cycle pulse: a sampling phase begins |
| conv_start | output | 1 | One-cycle pulse: the core should convert now |
| chan_num | output | 4 | Channel for the current conversion |
| chan_special | output | 1 | Channel code selects internal special channels |
| seq_done | output | 1 | Sticky sequence-complete flag |

## Verification
The hardest cases are the collisions with activity already under way: a control write that lands in the middle of a sampling phase, a trigger edge during a triggered sequence, and a stray `conv_done` while sampling. None of them is reached from idle. The bench drives random channel, mode and sample-time values through complete sequences, and from inside the sampling loop it injects stray `conv_done` and trigger pulses on chosen cycles. It also issues a directed abort write partway through a 24-cycle sampling phase, then checks the sampling length and channel order of the sequence that follows.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int CHAN_W    = 4;
   localparam int SMP_CNT_W = 5;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SAMPLE  = 2'd1,
      ST_CONVERT = 2'd2
   } seq_state_e;

   // Stored control bits (bit 7 of the register is reserved and not stored)
   typedef struct packed {
      logic              special;   // bit 6
      logic              cont;      // bit 5
      logic              mult;      // bit 4
      logic [CHAN_W-1:0] chan;      // bits 3..0
   } ctrl_reg_t;

   // Sampling phase length in converter clock cycles
   function automatic logic [SMP_CNT_W-1:0] smp_cycles(input logic [2:0] code);
      logic [SMP_CNT_W-1:0] n;
      case (code)
         3'd0:    n = SMP_CNT_W'(4);
         3'd1:    n = SMP_CNT_W'(6);
         3'd2:    n = SMP_CNT_W'(8);
         3'd3:    n = SMP_CNT_W'(10);
         3'd4:    n = SMP_CNT_W'(12);
         3'd5:    n = SMP_CNT_W'(16);
         3'd6:    n = SMP_CNT_W'(20);
         default: n = SMP_CNT_W'(24);
      endcase
      return n;
   endfunction

endpackage

// File: rtl/adc_seq_regif.sv
module adc_seq_regif
   import adc_seq_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int CTRL_ADDR = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   output logic [7:0]        reg_rdata,
   output logic              ctrl_wr,
   output ctrl_reg_t         ctrl_q,
   output ctrl_reg_t         ctrl_next
);

   localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

   logic hit;
   ctrl_reg_t wr_val;

   assign hit     = (reg_addr == SEL);
   assign ctrl_wr = reg_we && hit;
   assign wr_val  = ctrl_reg_t'(reg_wdata[6:0]);

   // The sequencer acts on the written value in the same cycle as the write
   assign ctrl_next = ctrl_wr ? wr_val : ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= wr_val;
      end
   end

   assign reg_rdata = hit ? {1'b0, ctrl_q} : 8'h00;

endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
   parameter bit TRIG_RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_trig,
   input  logic trig_en,
   input  logic arm_wr,
   input  logic idle,
   output logic trig_start
);

   logic trig_q;
   logic armed;
   logic edge_seen;

   generate
      if (TRIG_RISING) begin : g_rise
         assign edge_seen = ext_trig && !trig_q;
      end else begin : g_fall
         assign edge_seen = !ext_trig && trig_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         armed  <= 1'b0;
      end else begin
         trig_q <= ext_trig;
         if (!trig_en) begin
            armed <= 1'b0;
         end else if (arm_wr) begin
            armed <= 1'b1;
         end
      end
   end

   // A write in the same cycle takes priority: it re-arms and aborts
   assign trig_start = armed && trig_en && edge_seen && idle && !arm_wr;

endmodule

// File: rtl/adc_seq_smptimer.sv
module adc_seq_smptimer
   import adc_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [2:0] code,
   output logic       expired
);

   logic [SMP_CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= smp_cycles(code) - SMP_CNT_W'(1);
      end else if (cnt != '0) begin
         cnt <= cnt - SMP_CNT_W'(1);
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int CTRL_ADDR   = 5,
   parameter int SEQ_LEN     = 4,
   parameter bit TRIG_RISING = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              reg_we,
   output logic [7:0]        reg_rdata,
   input  logic              ext_trig,
   input  logic              trig_en,
   input  logic [2:0]        smp_sel,
   input  logic              conv_done,
   output logic              sample_start,
   output logic              conv_start,
   output logic [3:0]        chan_num,
   output logic              chan_special,
   output logic              seq_done
);

   localparam int IDX_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

   generate
      if (SEQ_LEN < 1 || SEQ_LEN > 256) begin : g_bad_len
         $error("SEQ_LEN out of range");
      end
      if (ADDR_W < 1 || CTRL_ADDR < 0 || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("CTRL_ADDR does not fit in ADDR_W");
      end
      if (SMP_CNT_W < 5) begin : g_bad_cnt
         $error("sample counter too narrow for 24 cycles");
      end
   endgenerate

   ctrl_reg_t  ctrl_q, ctrl_next;
   logic       ctrl_wr;
   logic       trig_start;
   logic       tmr_expired;
   seq_state_e state;
   logic [IDX_W-1:0] idx;
   logic [CHAN_W-1:0] chan_q;
   logic       special_q;

   logic is_last, done_acc, start_seq, step, begin_sample, to_convert, finish;
   logic [CHAN_W-1:0] chan_d;

   adc_seq_regif #(
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR)
   ) regif_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata),
      .ctrl_wr   (ctrl_wr),
      .ctrl_q    (ctrl_q),
      .ctrl_next (ctrl_next)
   );

   adc_seq_trig #(
      .TRIG_RISING (TRIG_RISING)
   ) trig_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ext_trig   (ext_trig),
      .trig_en    (trig_en),
      .arm_wr     (ctrl_wr),
      .idle       (state == ST_IDLE),
      .trig_start (trig_start)
   );

   adc_seq_smptimer timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (begin_sample),
      .code    (smp_sel),
      .expired (tmr_expired)
   );

   // Next-step decisions; a control write overrides everything else
   always_comb begin
      is_last    = (idx == LAST_IDX);
      done_acc   = !ctrl_wr && (state == ST_CONVERT) && conv_done;
      finish     = done_acc && is_last;
      step       = done_acc && !is_last;
      to_convert = !ctrl_wr && (state == ST_SAMPLE) && tmr_expired;
      start_seq  = (ctrl_wr && !trig_en)
                || trig_start
                || (finish && ctrl_q.cont && !trig_en);
      begin_sample = start_seq || step;
      if (start_seq) begin
         chan_d = ctrl_next.chan;
      end else if (ctrl_q.mult) begin
         chan_d = chan_q + CHAN_W'(1);
      end else begin
         chan_d = chan_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         idx          <= '0;
         chan_q       <= '0;
         special_q    <= 1'b0;
         sample_start <= 1'b0;
         conv_start   <= 1'b0;
         seq_done     <= 1'b0;
      end else begin
         sample_start <= begin_sample;
         conv_start   <= to_convert;

         if (begin_sample) begin
            state  <= ST_SAMPLE;
            chan_q <= chan_d;
         end else if (ctrl_wr || finish) begin
            state <= ST_IDLE;
         end else if (to_convert) begin
            state <= ST_CONVERT;
         end

         if (start_seq) begin
            idx       <= '0;
            special_q <= ctrl_next.special;
         end else if (step) begin
            idx <= idx + IDX_W'(1);
         end

         if (ctrl_wr) begin
            seq_done <= 1'b0;
         end else if (finish) begin
            seq_done <= 1'b1;
         end
      end
   end

   assign chan_num     = chan_q;
   assign chan_special = special_q;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int ADDR_W    = 4,
   parameter int CTRL_ADDR = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic [7:0]        reg_rdata,
   input logic              trig_en,
   input logic              conv_done,
   input logic              sample_start,
   input logic              conv_start,
   input logic [3:0]        chan_num,
   input logic              seq_done
);

   logic wr;
   assign wr = reg_we && (reg_addr == ADDR_W'(CTRL_ADDR));

   assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[7] == 1'b0);

   assert_wr_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !trig_en) |=> sample_start);

   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_start && conv_start));

   assert_conv_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   assert_chan_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_start |-> $stable(chan_num));

   assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !seq_done);

   assert_done_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_done) |-> $past(conv_done));

   assert_arm_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && trig_en) |=> !sample_start);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
   .ADDR_W    (ADDR_W),
   .CTRL_ADDR (CTRL_ADDR)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_addr     (reg_addr),
   .reg_we       (reg_we),
   .reg_rdata    (reg_rdata),
   .trig_en      (trig_en),
   .conv_done    (conv_done),
   .sample_start (sample_start),
   .conv_start   (conv_start),
   .chan_num     (chan_num),
   .seq_done     (seq_done)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 4;
   localparam int CTRL_ADDR  = 5;
   localparam int SEQ_LEN    = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [7:0]        reg_wdata = '0;
   logic              reg_we = 1'b0;
   logic [7:0]        reg_rdata;
   logic              ext_trig = 1'b0;
   logic              trig_en = 1'b0;
   logic [2:0]        smp_sel = '0;
   logic              conv_done = 1'b0;
   logic              sample_start, conv_start, chan_special, seq_done;
   logic [3:0]        chan_num;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_seq_ctrl #(
      .ADDR_W    (ADDR_W),
      .CTRL_ADDR (CTRL_ADDR),
      .SEQ_LEN   (SEQ_LEN)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_we       (reg_we),
      .reg_rdata    (reg_rdata),
      .ext_trig     (ext_trig),
      .trig_en      (trig_en),
      .smp_sel      (smp_sel),
      .conv_done    (conv_done),
      .sample_start (sample_start),
      .conv_start   (conv_start),
      .chan_num     (chan_num),
      .chan_special (chan_special),
      .seq_done     (seq_done)
   );

   function automatic int exp_cycles(input logic [2:0] code);
      case (code)
         3'd0: return 4;
         3'd1: return 6;
         3'd2: return 8;
         3'd3: return 10;
         3'd4: return 12;
         3'd5: return 16;
         3'd6: return 20;
         default: return 24;
      endcase
   endfunction

   function automatic logic [3:0] exp_chan(input logic [7:0] cv, input int i);
      return cv[4] ? 4'((int'(cv[3:0]) + i) % 16) : cv[3:0];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
      reg_addr  = ADDR_W'(CTRL_ADDR);
   endtask

   task automatic pulse_trig();
      @(negedge clk);
      ext_trig = 1'b1;
      @(negedge clk);
      ext_trig = 1'b0;
   endtask

   task automatic idle_chk(input int n, input string req);
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         chk(!sample_start && !conv_start, req, int'({sample_start, conv_start}), 0);
      end
   endtask

   // Called at the negedge where sample_start is expected high
   task automatic run_conv(input logic [3:0] ec, input logic esp, input logic [2:0] code,
                           input bit inj_done, input bit inj_trig);
      int k = 0;
      chk(sample_start === 1'b1, "R3/R7/R8 sample_start", int'(sample_start), 1);
      chk(chan_num == ec, "R5 chan_num", int'(chan_num), int'(ec));
      chk(chan_special == esp, "R5 chan_special", int'(chan_special), int'(esp));
      while (1) begin
         @(negedge clk);
         k++;
         if (conv_start || k > 40) break;
         if (k == 1) begin
            conv_done = inj_done;
            ext_trig  = inj_trig;
         end
         if (k == 2) conv_done = 1'b0;
         if (k == 3) ext_trig  = 1'b0;
      end
      chk(k == exp_cycles(code), inj_done ? "R10 stray done, sample length" : "R4 sample length",
          k, exp_cycles(code));
      repeat ($urandom_range(0, 3)) @(negedge clk);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic run_seq(input logic [7:0] cv, input logic [2:0] code,
                          input bit restart_exp, input bit inj);
      for (int i = 0; i < SEQ_LEN; i++) begin
         run_conv(exp_chan(cv, i), cv[6], code, inj && (i == 1), inj && (i == 2));
      end
      chk(seq_done === 1'b1, "R6 seq_done after last", int'(seq_done), 1);
      chk(sample_start === restart_exp, "R7/R6 restart", int'(sample_start), int'(restart_exp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] cv;
      void'($urandom(32'h5EC0_0C71));
      reg_addr = ADDR_W'(CTRL_ADDR);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(reg_rdata == 8'h00, "R1 rdata", int'(reg_rdata), 0);
      chk(!sample_start && !conv_start && !seq_done, "R1 outputs",
          int'({sample_start, conv_start, seq_done}), 0);

      // R2 register access, with trigger mode on so nothing starts
      trig_en = 1'b1;
      wr(ADDR_W'(CTRL_ADDR), 8'hFF);
      #1 chk(reg_rdata == 8'h7F, "R2 readback", int'(reg_rdata), 8'h7F);
      reg_addr = ADDR_W'(3);
      #1 chk(reg_rdata == 8'h00, "R2 other address read", int'(reg_rdata), 0);
      wr(ADDR_W'(3), 8'h12);
      #1 chk(reg_rdata == 8'h7F, "R2 other address write ignored", int'(reg_rdata), 8'h7F);
      idle_chk(3, "R2 no start");
      trig_en = 1'b0;

      // Random sequences, trigger disabled
      for (int it = 0; it < 24; it++) begin
         cv = {1'b0, 1'($urandom), (it % 4 == 3), 1'($urandom), 4'($urandom)};
         smp_sel = 3'(it % 8);
         wr(ADDR_W'(CTRL_ADDR), cv);
         chk(seq_done === 1'b0, "R6 cleared by write", int'(seq_done), 0);
         run_seq(cv, smp_sel, cv[5], (it % 3 == 0));
         if (!cv[5]) idle_chk(8, "R6 single stops");
      end

      // R3 abort in the middle of a long sampling phase
      smp_sel = 3'd7;
      wr(ADDR_W'(CTRL_ADDR), 8'h13);
      repeat (5) @(negedge clk);
      cv = 8'h5E;
      wr(ADDR_W'(CTRL_ADDR), cv);
      run_seq(cv, 3'd7, 1'b0, 1'b0);
      idle_chk(6, "R3 abort then single");

      // R9 unarmed trigger ignored
      trig_en = 1'b1;
      pulse_trig();
      idle_chk(10, "R9 unarmed trigger");

      // R8 arming write with continuous bit set starts nothing
      smp_sel = 3'd2;
      cv = 8'h3D;
      wr(ADDR_W'(CTRL_ADDR), cv);
      chk(seq_done === 1'b0, "R6 cleared by arming write", int'(seq_done), 0);
      idle_chk(6, "R8 arm without start");
      pulse_trig();
      run_seq(cv, 3'd2, 1'b0, 1'b1);   // trigger during run is ignored (R9)
      idle_chk(10, "R8 continuous ignored");
      smp_sel = 3'd0;
      pulse_trig();
      run_seq(cv, 3'd0, 1'b0, 1'b0);
      idle_chk(6, "R8 one sequence per trigger");

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule